// File: doc/BRIEF.md
# Accumulator ALU with Skip Logic

This block is the purely combinational arithmetic and logic stage of a small 8-bit accumulator machine. A 4-bit operation code picks one of ten functions: three additions (plain, with carry, subtract with carry), three bitwise logical functions, two accumulator compares, a compare of the low nibble of the B address register, and a decrement-register-and-skip-if-zero. The operands are the accumulator, a memory or immediate byte, the low nibble of B, a register-file byte and the incoming carry and half-carry flags.

Compares never branch. They raise a skip flag that tells the sequencer to discard the following instruction. The block also reports where its result goes: nowhere, into the accumulator, or back into the register operand. Subtraction treats the carry as "no borrow": it adds the inverted operand plus the carry, and it reports a half-carry taken from the same addition. Fetch, address generation and instruction sequencing belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (add) gives res_o = (acc_i + opnd_i) mod 256 and wr_o = 1 (accumulator). c_o and hc_o equal c_i and hc_i.
- R2: Code 1 (add with carry) gives res_o = (acc_i + opnd_i + c_i) mod 256 and wr_o = 1. c_o is the carry out of bit 7 and hc_o is the carry out of bit 3 of that same sum.
- R3: Code 2 (subtract with carry) gives res_o = (acc_i + ~opnd_i + c_i) mod 256 and wr_o = 1. c_o and hc_o are the carries out of bits 7 and 3 of that sum, so c_o = 1 means no borrow.
- R4: Codes 3, 4 and 5 give acc_i AND, OR and XOR opnd_i respectively, with wr_o = 1. The flags pass through unchanged.
- R5: Code 6 (equal test) sets skip_o exactly when acc_i differs from opnd_i.
- R6: Code 7 (greater test) sets skip_o exactly when acc_i is not greater than opnd_i, compared unsigned.
- R7: Code 8 (B nibble test) sets skip_o exactly when breg_lo_i equals opnd_i[3:0].
- R8: Code 9 (decrement) gives res_o = (regv_i - 1) mod 256 and wr_o = 2 (register). skip_o is set exactly when that new value is zero. The flags pass through unchanged.
- R9: Compare codes 6 to 8 and the unused codes 10 to 15 give wr_o = 0 and res_o = 0, and the flags pass through unchanged. The unused codes also leave skip_o low.
- R10: skip_o is low for every code from 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0..9 used) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Memory or immediate operand |
| breg_lo_i | input | 4 | Low nibble of the B address register |
| regv_i | input | 8 | Register-file operand for decrement |
| c_i | input | 1 | Incoming carry flag |
| hc_i | input | 1 | Incoming half-carry flag |
| res_o | output | 8 | Result byte |
| wr_o | output | 2 | Write target: 0 none, 1 accumulator, 2 register |
| c_o | output | 1 | Updated carry flag |
| hc_o | output | 1 | Updated half-carry flag |
| skip_o | output | 1 | Skip the next instruction |

## Verification
Uniform random codes and operands cover the ordinary cases. Because equal operands seldom occur at random, a share of the vectors force opnd_i equal to acc_i, or the B nibble equal to the operand nibble, so that the equal and not-equal sides of every compare are both reached. Directed vectors aim at the carry chain: 0x0F plus carry tests half-carry alone, 0xFF plus 0x01 tests the full wrap, and subtracting with and without an incoming carry separates a borrow from no borrow. A decrement of 1 must skip and a decrement of 0 must wrap to 0xFF without skipping, and every unused code is applied to show that it causes no write, no skip and no flag change.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUBC = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_IFEQ = 4'd6,
        OP_IFGT = 4'd7,
        OP_IFBN = 4'd8,
        OP_DRSZ = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_ACC  = 2'd1,
        WR_REG  = 2'd2
    } wr_tgt_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          cy;
        logic          hc;
    } sum_t;

    // Ripple sum split at the nibble boundary so the half-carry falls out directly.
    function automatic sum_t add_split(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                       input logic cin);
        logic [NW:0] lo;
        logic [NW:0] hi;
        sum_t r;
        lo = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        hi = {1'b0, a[DW-1:NW]} + {1'b0, b[DW-1:NW]} + {{NW{1'b0}}, lo[NW]};
        r.val = {hi[NW-1:0], lo[NW-1:0]};
        r.cy  = hi[NW];
        r.hc  = lo[NW];
        return r;
    endfunction

    function automatic logic is_arith(input logic [3:0] op);
        return (op == OP_ADC) || (op == OP_SUBC);
    endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    input  logic          cin_i,
    output sum_t          sum_o
);
    logic [DW-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = add_split(a_i, b_eff, cin_i);
    end

    // With carry in set, subtract carry equals "a >= b" (R3).
    always_comb begin
        if (sub_i && cin_i)
            assert_subc_noborrow_R3: assert (sum_o.cy == (a_i >= b_i));
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import acc_alu_pkg::*;
(
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            default: y_o = a_i ^ b_i;
        endcase
    end

    always_comb begin
        if (op_i == OP_AND)
            assert_and_subset_R4: assert ((y_o & ~a_i) == '0);
    end
endmodule

// File: rtl/alu_skip.sv
module alu_skip
    import acc_alu_pkg::*;
(
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [NW-1:0] bnib_i,
    input  logic [DW-1:0] dec_i,
    output logic          skip_o
);
    logic eq_acc, gt_acc, eq_nib, dec_zero;

    always_comb begin
        eq_acc   = (acc_i == opnd_i);
        gt_acc   = (acc_i > opnd_i);
        eq_nib   = (bnib_i == opnd_i[NW-1:0]);
        dec_zero = (dec_i == '0);
        case (op_i)
            OP_IFEQ: skip_o = !eq_acc;
            OP_IFGT: skip_o = !gt_acc;
            OP_IFBN: skip_o = eq_nib;
            OP_DRSZ: skip_o = dec_zero;
            default: skip_o = 1'b0;
        endcase
    end

    // Greater and equal cannot both hold, so a greater test skips whenever equal (R6).
    always_comb begin
        if (op_i == OP_IFGT && eq_acc)
            assert_gt_equal_skips_R6: assert (skip_o);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [NW-1:0] breg_lo_i,
    input  logic [DW-1:0] regv_i,
    input  logic          c_i,
    input  logic          hc_i,
    output logic [DW-1:0] res_o,
    output logic [1:0]    wr_o,
    output logic          c_o,
    output logic          hc_o,
    output logic          skip_o
);
    sum_t          ad_sum;
    logic [DW-1:0] lg_y;
    logic [DW-1:0] dec_v;
    logic          add_cin;

    always_comb begin
        add_cin = (op_i == OP_ADD) ? 1'b0 : c_i;
        dec_v   = regv_i - {{(DW-1){1'b0}}, 1'b1};
    end

    alu_adder u_add (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .sub_i (op_i == OP_SUBC),
        .cin_i (add_cin),
        .sum_o (ad_sum)
    );

    alu_logic u_log (
        .op_i (op_i),
        .a_i  (acc_i),
        .b_i  (opnd_i),
        .y_o  (lg_y)
    );

    alu_skip u_skp (
        .op_i   (op_i),
        .acc_i  (acc_i),
        .opnd_i (opnd_i),
        .bnib_i (breg_lo_i),
        .dec_i  (dec_v),
        .skip_o (skip_o)
    );

    always_comb begin
        res_o = '0;
        wr_o  = WR_NONE;
        c_o   = c_i;
        hc_o  = hc_i;
        case (op_i)
            OP_ADD, OP_ADC, OP_SUBC: begin
                res_o = ad_sum.val;
                wr_o  = WR_ACC;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_o = lg_y;
                wr_o  = WR_ACC;
            end
            OP_DRSZ: begin
                res_o = dec_v;
                wr_o  = WR_REG;
            end
            default: ;
        endcase
        if (is_arith(op_i)) begin
            c_o  = ad_sum.cy;
            hc_o = ad_sum.hc;
        end
    end

    always_comb begin
        if (op_i <= OP_XOR)
            assert_no_skip_alu_R10: assert (!skip_o);
        if (op_i > OP_DRSZ)
            assert_unused_idle_R9: assert (wr_o == WR_NONE && !skip_o && res_o == '0);
        if (op_i == OP_DRSZ)
            assert_drsz_skip_R8: assert (skip_o == (regv_i == 8'd1));
        if (wr_o == WR_NONE)
            assert_nowrite_flags_R9: assert (c_o == c_i && hc_o == hc_i);
    end
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] acc, opnd, regv, res;
    logic [3:0] bnib;
    logic       ci, hci, co, hco, skip;
    logic [1:0] wr;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    acc_alu dut (
        .op_i(op), .acc_i(acc), .opnd_i(opnd), .breg_lo_i(bnib), .regv_i(regv),
        .c_i(ci), .hc_i(hci), .res_o(res), .wr_o(wr), .c_o(co), .hc_o(hco),
        .skip_o(skip)
    );

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd4, 4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Reference model: {res, wr, c, hc, skip}
    function automatic logic [12:0] model(input logic [3:0] o, input logic [7:0] a,
            input logic [7:0] b, input logic [3:0] bn, input logic [7:0] r,
            input logic c, input logic h);
        int s, lo;
        logic [7:0] y = 8'h00;
        logic [1:0] w = 2'd0;
        logic cc = c, hh = h, sk = 1'b0;
        int bb;
        case (o)
            4'd0: begin y = 8'((int'(a) + int'(b)) % 256); w = 2'd1; end
            4'd1, 4'd2: begin
                bb = (o == 4'd2) ? (255 - int'(b)) : int'(b);
                s  = int'(a) + bb + int'(c);
                lo = int'(a % 16) + (bb % 16) + int'(c);
                y = 8'(s % 256); cc = (s > 255); hh = (lo > 15); w = 2'd1;
            end
            4'd3: begin y = a & b; w = 2'd1; end
            4'd4: begin y = a | b; w = 2'd1; end
            4'd5: begin y = a ^ b; w = 2'd1; end
            4'd6: sk = (a != b);
            4'd7: sk = !(a > b);
            4'd8: sk = (bn == b[3:0]);
            4'd9: begin y = 8'((int'(r) + 255) % 256); w = 2'd2; sk = (y == 8'h00); end
            default: ;
        endcase
        return {y, w, cc, hh, sk};
    endfunction

    task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [3:0] bn, input logic [7:0] r, input logic c,
                         input logic h);
        logic [12:0] exp_v, got;
        @(posedge clk);
        op = o; acc = a; opnd = b; bnib = bn; regv = r; ci = c; hci = h;
        @(negedge clk);
        exp_v = model(o, a, b, bn, r, c, h);
        got   = {res, wr, co, hco, skip};
        n_vec++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%02h b=%02h bn=%h r=%02h c=%b hc=%b: got res=%02h wr=%0d c=%b hc=%b sk=%b expected res=%02h wr=%0d c=%b hc=%b sk=%b",
                     req_of(o), o, a, b, bn, r, c, h, got[12:5], got[4:3], got[2], got[1],
                     got[0], exp_v[12:5], exp_v[4:3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b;
        logic [3:0] o;
        int unused_s;
        unused_s = $urandom(32'h5A17);
        op = 4'd15; acc = 0; opnd = 0; bnib = 0; regv = 0; ci = 0; hci = 0;
        // Idle state: unused code, all-zero inputs (R9)
        apply(4'd15, 8'h00, 8'h00, 4'h0, 8'h00, 1'b0, 1'b0);
        // Directed corners
        apply(4'd0, 8'hFF, 8'h01, 4'h0, 8'h00, 1'b1, 1'b0);  // R1 wrap, flags kept
        apply(4'd1, 8'h0F, 8'h00, 4'h0, 8'h00, 1'b1, 1'b0);  // R2 half-carry only
        apply(4'd1, 8'hFF, 8'h00, 4'h0, 8'h00, 1'b1, 1'b0);  // R2 full carry
        apply(4'd2, 8'h00, 8'h01, 4'h0, 8'h00, 1'b1, 1'b1);  // R3 borrow
        apply(4'd2, 8'h05, 8'h05, 4'h0, 8'h00, 1'b1, 1'b0);  // R3 equal, no borrow
        apply(4'd2, 8'h05, 8'h05, 4'h0, 8'h00, 1'b0, 1'b0);  // R3 carry in clear
        apply(4'd3, 8'hF0, 8'h3C, 4'h0, 8'h00, 1'b1, 1'b1);  // R4
        apply(4'd4, 8'hF0, 8'h3C, 4'h0, 8'h00, 1'b0, 1'b1);  // R4
        apply(4'd5, 8'hF0, 8'h3C, 4'h0, 8'h00, 1'b1, 1'b0);  // R4
        apply(4'd6, 8'h42, 8'h42, 4'h0, 8'h00, 1'b0, 1'b0);  // R5 equal
        apply(4'd6, 8'h42, 8'h43, 4'h0, 8'h00, 1'b0, 1'b0);  // R5 differ
        apply(4'd7, 8'h80, 8'h80, 4'h0, 8'h00, 1'b0, 1'b0);  // R6 equal skips
        apply(4'd7, 8'h81, 8'h7F, 4'h0, 8'h00, 1'b0, 1'b0);  // R6 unsigned greater
        apply(4'd8, 8'h00, 8'hA7, 4'h7, 8'h00, 1'b0, 1'b0);  // R7 nibble match
        apply(4'd8, 8'h00, 8'hA7, 4'h6, 8'h00, 1'b0, 1'b0);  // R7 no match
        apply(4'd9, 8'h00, 8'h00, 4'h0, 8'h01, 1'b1, 1'b1);  // R8 to zero
        apply(4'd9, 8'h00, 8'h00, 4'h0, 8'h00, 1'b0, 1'b1);  // R8 wrap
        for (int k = 10; k < 16; k++)
            apply(4'(k), 8'hFF, 8'hFF, 4'hF, 8'h01, 1'b1, 1'b0);  // R9
        for (int k = 0; k < 6; k++)
            apply(4'(k), 8'h11, 8'h11, 4'h1, 8'h01, 1'b0, 1'b0);  // R10
        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            o = 4'($urandom_range(0, 15));
            a = 8'($urandom);
            b = ($urandom_range(0, 3) == 0) ? a : 8'($urandom);
            apply(o, a, b, ($urandom_range(0, 3) == 0) ? b[3:0] : 4'($urandom),
                  ($urandom_range(0, 7) == 0) ? 8'd1 : 8'($urandom),
                  1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule